// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single register transactions on the two-wire management bus of an Ethernet PHY. A request carries a read/write flag, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The block builds the serial frame, produces the management clock from the system clock, and drives or releases the data line through separate output, output-enable and input pins, so a pad cell outside the block forms the tri-state line.

Each bit is a low half period followed by a high phase. Bits the master drives use one half period for the high phase. Bits the PHY drives use a longer, separately set high phase, which leaves the PHY time to present data before it is sampled on the falling clock. A read checks the first turnaround bit from the PHY. If that bit is not low, the block clocks the PHY through a flush window and reports all-ones with an error flag. Busy and a one-cycle done pulse frame every transaction.

Top module: `mdio_master`

## Requirements
- R1: While idle or in reset, `mdc` is low, `mdio_oe` is low and `busy` is low. A reset in the middle of a frame returns the block to this state at once.
- R2: Every frame starts with 32 driven 1 bits. Then come the start bits 0,1 and the opcode: 1,0 for a read, 0,1 for a write. The PHY address follows, then the register address, each 5 bits wide and sent MSB first. Every one of these bits is driven with `mdio_oe` high and holds its value at the rising edge of `mdc`.
- R3: A write then drives the turnaround 1,0 and the 16 data bits MSB first, 64 driven bits in all. After that the block releases the line for exactly one more `mdc` cycle.
- R4: A read releases the line right after the register address. If the first released bit is sampled low, the next 16 released bits are shifted into `rd_data` MSB first, one more released cycle follows, and `rd_err` stays low. That is 18 released cycles.
- R5: If the first released bit of a read is sampled high, the block runs 32 more released cycles (33 in all), then ends with `rd_data` = 16'hFFFF and `rd_err` high.
- R6: `mdio_o` and `mdio_oe` never change while `mdc` is high.
- R7: Within a frame, `mdc` stays low for `HALF_CYC` system clocks on every bit. It stays high for `HALF_CYC` clocks on driven bits and for `RDHI_CYC` clocks on released bits.
- R8: A request is taken only in a cycle where `busy` is low. `busy` is high from the cycle after acceptance until the frame ends. `done` pulses for exactly one cycle at the end, with `busy` already low, and a request made while busy has no effect on the frame in progress.
- R9: Accepting a request clears `rd_err` and sets `rd_data` to zero, so a write leaves `rd_data` at zero. Both outputs then hold until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_read | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write value |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rd_data | output | 16 | Read result |
| rd_err | output | 1 | Turnaround check failed on last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input from the pad |

## Verification
The assertions assume that `mdio_i` is synchronous enough to pass through the input synchronizer. They also assume that each released bit stays stable from shortly after the rising `mdc` edge until the sampling fall, and that `RDHI_CYC` exceeds the synchronizer depth. The bench's PHY model changes `mdio_i` only on the sample after a rising `mdc` and holds it through the whole high phase. It drives a pulled-up 1 whenever it has nothing to return. Requests are made only as single-cycle strobes, away from the clock edge. Raising one while busy is tested on purpose.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;

  localparam int PRE_BITS   = 32;
  localparam int ADDR_BITS  = 5;
  localparam int DATA_BITS  = 16;
  localparam int HDR_BITS   = PRE_BITS + 4 + 2 * ADDR_BITS;
  localparam int WR_BITS    = HDR_BITS + 2 + DATA_BITS;
  localparam int FLUSH_BITS = 32;
  localparam int LEN_W      = $clog2(WR_BITS + 1);
  localparam int RCNT_W     = $clog2(FLUSH_BITS + 1);

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_SEND, SQ_TA, SQ_RDATA, SQ_FLUSH, SQ_TAIL
  } seq_state_e;

  typedef enum logic [1:0] {
    TM_IDLE, TM_LOW, TM_HIGH
  } tm_state_e;

  // Complete driven bit sequence, first bit in the MSB; a read uses the top HDR_BITS
  function automatic logic [WR_BITS-1:0] build_frame(
    input logic                 rd,
    input logic [ADDR_BITS-1:0] phy,
    input logic [ADDR_BITS-1:0] rga,
    input logic [DATA_BITS-1:0] wd
  );
    logic [1:0] opc;
    opc = rd ? 2'b10 : 2'b01;
    return {{PRE_BITS{1'b1}}, 2'b01, opc, phy, rga, 2'b10, wd};
  endfunction

  function automatic logic [LEN_W-1:0] drive_len(input logic rd);
    return rd ? LEN_W'(HDR_BITS) : LEN_W'(WR_BITS);
  endfunction

  function automatic int unsigned high_len(input logic rx, input int unsigned half_c,
                                           input int unsigned rdhi_c);
    return rx ? rdhi_c : half_c;
  endfunction

endpackage

// File: rtl/mdio_in_sync.sv
module mdio_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2+((STAGES==1)?1:0):0] , d} ;
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/mdio_bit_timer.sv
module mdio_bit_timer
  import mdio_master_pkg::*;
#(
  parameter int HALF_CYC = 32,
  parameter int RDHI_CYC = 44
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic rx,
  output logic mdc,
  output logic bit_end
);
  localparam int MAXC = (HALF_CYC > RDHI_CYC) ? HALF_CYC : RDHI_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF_CYC - 1);

  tm_state_e      st;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  hi_last;
  logic           mdc_q;

  always_comb begin
    hi_last = CW'(high_len(rx, HALF_CYC, RDHI_CYC) - 1);
    bit_end = (st == TM_HIGH) && (cnt == hi_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= TM_IDLE;
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else begin
      unique case (st)
        TM_IDLE: begin
          mdc_q <= 1'b0;
          if (go) begin
            st  <= TM_LOW;
            cnt <= '0;
          end
        end
        TM_LOW: begin
          if (cnt == HALF_LAST) begin
            st    <= TM_HIGH;
            cnt   <= '0;
            mdc_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        TM_HIGH: begin
          if (bit_end) begin
            mdc_q <= 1'b0;
            cnt   <= '0;
            st    <= go ? TM_LOW : TM_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= TM_IDLE;
      endcase
    end
  end

  assign mdc = mdc_q;
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_master_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_read,
  input  logic [ADDR_BITS-1:0] req_phy,
  input  logic [ADDR_BITS-1:0] req_reg,
  input  logic [DATA_BITS-1:0] req_wdata,
  input  logic                 bit_end,
  input  logic                 rx_bit,
  output logic                 go,
  output logic                 rx_mode,
  output logic                 accept,
  output logic                 ta_fail,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 busy,
  output logic                 done,
  output logic [DATA_BITS-1:0] rd_data,
  output logic                 rd_err
);
  seq_state_e           st;
  logic [WR_BITS-1:0]   shreg;
  logic [WR_BITS-1:0]   frame_new;
  logic [LEN_W-1:0]     left;
  logic [RCNT_W-1:0]    rcnt;
  logic                 op_rd;
  logic                 mdo_q, oe_q, done_q, err_q;
  logic [DATA_BITS-1:0] rdata_q;
  logic                 last_bit;

  always_comb begin
    frame_new = build_frame(req_read, req_phy, req_reg, req_wdata);
    accept    = (st == SQ_IDLE) && req_valid;
    last_bit  = bit_end && ((st == SQ_TAIL) ||
                            ((st == SQ_FLUSH) && (rcnt == RCNT_W'(1))));
    go        = accept || (bit_end && !last_bit);
    rx_mode   = (st == SQ_TA) || (st == SQ_RDATA) ||
                (st == SQ_FLUSH) || (st == SQ_TAIL);
    ta_fail   = bit_end && (st == SQ_TA) && rx_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      shreg   <= '0;
      left    <= '0;
      rcnt    <= '0;
      op_rd   <= 1'b0;
      mdo_q   <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        SQ_IDLE: begin
          if (accept) begin
            shreg   <= frame_new;
            left    <= drive_len(req_read);
            op_rd   <= req_read;
            mdo_q   <= frame_new[WR_BITS-1];
            oe_q    <= 1'b1;
            err_q   <= 1'b0;
            rdata_q <= '0;
            st      <= SQ_SEND;
          end
        end
        SQ_SEND: begin
          if (bit_end) begin
            if (left == LEN_W'(1)) begin
              oe_q  <= 1'b0;
              mdo_q <= 1'b0;
              st    <= op_rd ? SQ_TA : SQ_TAIL;
            end else begin
              left  <= left - 1'b1;
              shreg <= {shreg[WR_BITS-2:0], 1'b0};
              mdo_q <= shreg[WR_BITS-2];
            end
          end
        end
        SQ_TA: begin
          if (bit_end) begin
            if (rx_bit) begin
              err_q   <= 1'b1;
              rdata_q <= '1;
              rcnt    <= RCNT_W'(FLUSH_BITS);
              st      <= SQ_FLUSH;
            end else begin
              rcnt <= RCNT_W'(DATA_BITS);
              st   <= SQ_RDATA;
            end
          end
        end
        SQ_RDATA: begin
          if (bit_end) begin
            rdata_q <= {rdata_q[DATA_BITS-2:0], rx_bit};
            if (rcnt == RCNT_W'(1)) st <= SQ_TAIL;
            else                    rcnt <= rcnt - 1'b1;
          end
        end
        SQ_FLUSH: begin
          if (bit_end) begin
            if (rcnt == RCNT_W'(1)) begin
              st     <= SQ_IDLE;
              done_q <= 1'b1;
            end else begin
              rcnt <= rcnt - 1'b1;
            end
          end
        end
        SQ_TAIL: begin
          if (bit_end) begin
            st     <= SQ_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign mdio_o  = mdo_q;
  assign mdio_oe = oe_q;
  assign busy    = (st != SQ_IDLE);
  assign done    = done_q;
  assign rd_data = rdata_q;
  assign rd_err  = err_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_master_pkg::*;
#(
  parameter int HALF_CYC    = 32,
  parameter int RDHI_CYC    = 44,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_read,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        rd_err,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  // named internal events, observed by the bound checker
  logic bit_go;
  logic bit_rx;
  logic bit_end;
  logic rx_bit;
  logic frame_accept;
  logic ta_fail;

  mdio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (mdio_i),
    .q     (rx_bit)
  );

  mdio_bit_timer #(.HALF_CYC(HALF_CYC), .RDHI_CYC(RDHI_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (bit_go),
    .rx      (bit_rx),
    .mdc     (mdc),
    .bit_end (bit_end)
  );

  mdio_frame_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_read  (req_read),
    .req_phy   (req_phy),
    .req_reg   (req_reg),
    .req_wdata (req_wdata),
    .bit_end   (bit_end),
    .rx_bit    (rx_bit),
    .go        (bit_go),
    .rx_mode   (bit_rx),
    .accept    (frame_accept),
    .ta_fail   (ta_fail),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .busy      (busy),
    .done      (done),
    .rd_data   (rd_data),
    .rd_err    (rd_err)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int HALF_CYC = 32,
  parameter int RDHI_CYC = 44
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [15:0] rd_data,
  input logic        rd_err,
  input logic        bit_rx,
  input logic        frame_accept,
  input logic        ta_fail
);
  logic [15:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= mdc ? hi_cnt + 1'b1 : 16'd0;
      lo_cnt <= (busy && !mdc) ? lo_cnt + 1'b1 : 16'd0;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  assert_first_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mdio_oe && mdio_o));

  assert_released_rx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_rx |-> !mdio_oe);

  assert_fail_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_err && !busy) |-> (rd_data == 16'hFFFF));

  assert_ta_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ta_fail |=> rd_err);

  assert_stable_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_high_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |-> (hi_cnt == ($past(bit_rx) ? 16'(RDHI_CYC) : 16'(HALF_CYC))));

  assert_low_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> (lo_cnt == 16'(HALF_CYC)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_accept |=> busy);
endmodule

bind mdio_master mdio_master_chk #(.HALF_CYC(HALF_CYC), .RDHI_CYC(RDHI_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .mdc          (mdc),
  .mdio_o       (mdio_o),
  .mdio_oe      (mdio_oe),
  .rd_data      (rd_data),
  .rd_err       (rd_err),
  .bit_rx       (bit_rx),
  .frame_accept (frame_accept),
  .ta_fail      (ta_fail)
);

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  localparam int HALF = 4;
  localparam int RDHI = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_read = 1'b0;
  logic [4:0]  req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, rd_err, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic        mdio_i = 1'b1;

  int checks = 0, errors = 0;

  // PHY model state
  logic        ta_val = 1'b0;
  logic [15:0] phy_data = '0;
  logic [63:0] cap_vec;
  int ncap, nrel, ndone, tbad, hi_run, lo_run;
  logic prev_mdc = 1'b0, cur_drv = 1'b0;

  // {rd, phy, reg, wdata, phy read data, turnaround ok}
  localparam logic [43:0] VEC [0:5] = '{
    {1'b0, 5'h01, 5'h00, 16'h1234, 16'h0000, 1'b1},
    {1'b1, 5'h1F, 5'h1F, 16'h0000, 16'hA5C3, 1'b1},
    {1'b0, 5'h10, 5'h0A, 16'h8001, 16'h0000, 1'b1},
    {1'b1, 5'h00, 5'h01, 16'h0000, 16'h0000, 1'b1},
    {1'b1, 5'h05, 5'h02, 16'h0000, 16'h7E11, 1'b0},
    {1'b0, 5'h1F, 5'h1F, 16'h0000, 16'h0000, 1'b1}
  };

  always #4 clk = ~clk;

  mdio_master #(.HALF_CYC(HALF), .RDHI_CYC(RDHI), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .rd_err(rd_err),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  task automatic chk(input string rq, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // PHY model and port-level timing monitor
  initial begin
    forever begin
      @(negedge clk);
      if (mdc && !prev_mdc) begin
        if (busy && lo_run != HALF) tbad++;
        lo_run = 0;
        hi_run = 1;
        cur_drv = mdio_oe;
        if (mdio_oe) begin
          cap_vec = {cap_vec[62:0], mdio_o};
          ncap++;
        end else begin
          if (nrel == 0)      mdio_i = ta_val;
          else if (nrel <= 16) mdio_i = phy_data[16 - nrel];
          else                 mdio_i = 1'b1;
          nrel++;
        end
      end else if (mdc) begin
        hi_run++;
      end else if (prev_mdc) begin
        if (hi_run != (cur_drv ? HALF : RDHI)) tbad++;
        hi_run = 0;
        lo_run = busy ? 1 : 0;
      end else if (busy) begin
        lo_run++;
      end else begin
        lo_run = 0;
        mdio_i = 1'b1;
      end
      if (done) ndone++;
      prev_mdc = mdc;
    end
  end

  task automatic clear_mon();
    cap_vec = '0; ncap = 0; nrel = 0; ndone = 0; tbad = 0;
  endtask

  task automatic issue(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_read = rd; req_phy = phy; req_reg = rg; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic frame_check(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] wd, input logic [15:0] pd, input logic ok);
    logic [63:0] exp;
    int en;
    exp = '0; en = 0;
    for (int i = 0; i < 32; i++) begin exp = {exp[62:0], 1'b1}; en++; end
    exp = {exp[61:0], 2'b01}; en += 2;
    exp = {exp[61:0], rd, ~rd}; en += 2;
    for (int i = 4; i >= 0; i--) begin exp = {exp[62:0], phy[i]}; en++; end
    for (int i = 4; i >= 0; i--) begin exp = {exp[62:0], rg[i]}; en++; end
    if (!rd) begin
      exp = {exp[61:0], 2'b10}; en += 2;
      for (int i = 15; i >= 0; i--) begin exp = {exp[62:0], wd[i]}; en++; end
    end
    chk(rd ? "R2" : "R3", "driven bit count", 64'(ncap), 64'(en));
    if (ncap == 64 && !rd) chk("R2", "header bits", cap_vec >> 18, exp >> 18);
    chk(rd ? "R2" : "R3", "driven bits", cap_vec, exp);
    if (!rd) begin
      chk("R3", "released cycles after write", 64'(nrel), 64'd1);
      chk("R9", "rd_data after write", 64'(rd_data), 64'h0);
      chk("R9", "rd_err after write", 64'(rd_err), 64'h0);
    end else if (ok) begin
      chk("R4", "released cycles on read", 64'(nrel), 64'd18);
      chk("R4", "read data", 64'(rd_data), 64'(pd));
      chk("R4", "rd_err on good read", 64'(rd_err), 64'h0);
    end else begin
      chk("R5", "released cycles on flush", 64'(nrel), 64'd33);
      chk("R5", "rd_data on failed turnaround", 64'(rd_data), 64'hFFFF);
      chk("R5", "rd_err on failed turnaround", 64'(rd_err), 64'h1);
    end
    chk("R7", "mdc phase length errors", 64'(tbad), 64'h0);
    chk("R8", "done pulses", 64'(ndone), 64'h1);
    chk("R8", "busy after frame", 64'(busy), 64'h0);
    chk("R1", "idle mdc/oe", 64'({mdc, mdio_oe}), 64'h0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    chk("R1", "reset state", 64'({mdc, mdio_oe, busy, done}), 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "idle after reset", 64'({mdc, mdio_oe, busy, rd_err}), 64'h0);

    for (int v = 0; v < 6; v++) begin
      logic [43:0] e;
      e = VEC[v];
      clear_mon();
      ta_val = ~e[0];
      phy_data = e[16:1];
      issue(e[43], e[42:38], e[37:33], e[32:17]);
      wait_done();
      frame_check(e[43], e[42:38], e[37:33], e[32:17], e[16:1], e[0]);
    end

    // R8: a request while busy is ignored
    clear_mon();
    ta_val = 1'b0; phy_data = 16'h0F0F;
    issue(1'b0, 5'h0C, 5'h03, 16'hBEEF);
    repeat (40) @(negedge clk);
    chk("R8", "busy during frame", 64'(busy), 64'h1);
    issue(1'b1, 5'h13, 5'h1C, 16'h0000);
    wait_done();
    frame_check(1'b0, 5'h0C, 5'h03, 16'hBEEF, 16'h0, 1'b1);
    repeat (10) @(negedge clk);
    chk("R8", "no second frame after busy request", 64'(busy), 64'h0);

    // R5 then R9: error is cleared by the next accepted read
    clear_mon();
    ta_val = 1'b1; phy_data = 16'h1111;
    issue(1'b1, 5'h02, 5'h04, 16'h0);
    wait_done();
    frame_check(1'b1, 5'h02, 5'h04, 16'h0, 16'h0, 1'b0);
    clear_mon();
    ta_val = 1'b0; phy_data = 16'h5A0F;
    issue(1'b1, 5'h02, 5'h04, 16'h0);
    @(negedge clk);
    chk("R9", "rd_err cleared on accept", 64'(rd_err), 64'h0);
    wait_done();
    frame_check(1'b1, 5'h02, 5'h04, 16'h0, 16'h5A0F, 1'b1);

    // R1: reset in the middle of a frame
    clear_mon();
    issue(1'b0, 5'h07, 5'h07, 16'hCAFE);
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "mid-frame reset", 64'({mdc, mdio_oe, busy}), 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    clear_mon();
    ta_val = 1'b0; phy_data = 16'hFFFE;
    issue(1'b1, 5'h11, 5'h12, 16'h0);
    wait_done();
    frame_check(1'b1, 5'h11, 5'h12, 16'h0, 16'hFFFE, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule